// File: doc/BRIEF.md
# Dual Programmable Timer with Event Capture and PWM

This block holds two programmable counters of parameterized width (32 bits by default), each with its own control word, reload value and live count. A timer in interval mode counts toward its terminal value, which is all ones when counting up and zero when counting down. At the terminal value it reloads, marks its interrupt status and gives a one-cycle event pulse on a dedicated output. It can do this once or repeatedly. A timer in capture mode counts freely. On the chosen edge of its external capture input it copies the running count into a capture register and marks its status. The capture input is first resynchronized through two flops.

When the PWM bit of timer 0 is set, the two timers drive one waveform together. Every reload of timer 0 starts a new period: the output goes high and timer 1 is restarted from its reload value. The terminal count of timer 1 ends the high phase. A freeze input holds both counters, and with them the event and PWM outputs, for as long as it is asserted.

Software reaches the block through a simple word-addressed register port with a 32-bit data bus and per-byte write enables. The read data is combinational.

Top module: `dual_tmr_pwm`

## Requirements
- R1: After reset, every register reads zero, and `evt_out`, `irq_out` and `pwm_out` are low.
- R2: The address is `reg_addr[2]` = timer and `reg_addr[1:0]` = 0 control, 1 reload, 2 count, 3 capture. A write changes only the byte lanes whose `reg_be` bit is set. Control bits 0..7 live in lane 0 and bit 8 lives in lane 1.
- R3: The control bits are: 0 run, 1 capture mode, 2 count down, 3 auto-reload, 4 interrupt enable, 5 capture on falling edge, 6 PWM (timer 0 only), 8 status. In interval mode with auto-reload set, a timer reloads at its terminal count. Events come every L+1 cycles when counting down from reload L, and every 2^CW−L cycles when counting up. Each terminal count gives a one-cycle pulse on `evt_out`.
- R4: With auto-reload clear, the terminal count reloads the counter, sets the status bit and clears the run bit. No further event follows.
- R5: The status bit is set by a terminal count or a capture. Writing 1 to bit 8 with lane 1 enabled clears it. Writing 0, or writing with lane 1 disabled, leaves it unchanged. `irq_out[t]` equals status AND interrupt enable.
- R6: When a status set and a clear-write fall in the same cycle, the status stays set.
- R7: In capture mode with run set, the selected edge on `cap_in[t]` copies the count into the capture register and sets the status bit. The copy happens at the third rising clock edge after the input changes. The opposite edge is ignored, and no event pulse is produced.
- R8: While `freeze` is high, neither counter changes, no terminal count occurs, and `pwm_out` holds its level.
- R9: With PWM enabled and both timers counting down with auto-reload, the output period is P+1 cycles with P the timer-0 reload value. The high time is H+1 cycles with H the timer-1 reload value. If H ≥ P, the output stays high. With PWM disabled, the output is low.
- R10: Writing 1 to control bit 7 loads the counter from the reload register at that edge. Bit 7 always reads 0.
- R11: The count and capture registers are read-only: writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| freeze | input | 1 | Holds both counters while high |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Word address: timer select and register select |
| reg_be | input | 4 | Byte-lane write enables |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| cap_in | input | 2 | Asynchronous capture inputs, one per timer |
| evt_out | output | 2 | One-cycle terminal-count event pulses |
| irq_out | output | 2 | Interrupt requests, status AND enable |
| pwm_out | output | 1 | PWM waveform |

## Verification
A clear-write to a timer's status bit can land in the same cycle as a fresh terminal count that sets it again. The bench provokes this with a timer counting down from reload 0, which produces a terminal count every cycle. It issues the clear while that timer runs, and again in the same write that stops it. The bench then expects the status to read back as set, and expects only a further clear, issued once the timer is idle, to empty it. The PWM path has a similar collision when the high time equals the period. There, the set from timer 0 must win over the clear from timer 1, and the bench judges this by an output that never drops.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;

  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_LOAD  = 2'd1,
    SEL_COUNT = 2'd2,
    SEL_CAPT  = 2'd3
  } reg_sel_e;

  localparam int B_PWM   = 6;
  localparam int B_LDNOW = 7;
  localparam int B_STS   = 8;

  // stored control bits, bit 6 down to bit 0
  typedef struct packed {
    logic pwm_en;
    logic fall;
    logic ien;
    logic auto_rl;
    logic down;
    logic cap_mode;
    logic run;
  } ctrl_t;

  function automatic logic [31:0] be_merge(input logic [31:0] old_v,
                                           input logic [31:0] new_v,
                                           input logic [3:0]  be);
    logic [31:0] r;
    for (int b = 0; b < 4; b++)
      r[8*b +: 8] = be[b] ? new_v[8*b +: 8] : old_v[8*b +: 8];
    return r;
  endfunction

endpackage

// File: rtl/dtmr_edge.sv
module dtmr_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din_i,
  input  logic fall_i,
  output logic hit_o
);
  logic [STAGES:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-1:0], din_i};
  end

  // sync_q[STAGES-1] is the resynchronized level, sync_q[STAGES] its previous value
  assign hit_o = fall_i ? (sync_q[STAGES] & ~sync_q[STAGES-1])
                        : (~sync_q[STAGES] & sync_q[STAGES-1]);
endmodule

// File: rtl/dtmr_chan.sv
module dtmr_chan
  import dtmr_pkg::*;
#(
  parameter int CW          = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          freeze_i,
  input  logic          ctrl_we_i,
  input  logic          load_we_i,
  input  logic [31:0]   wdata_i,
  input  logic [3:0]    be_i,
  input  logic          sync_i,
  input  logic          cap_i,
  output logic [31:0]   ctrl_o,
  output logic [CW-1:0] load_o,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] capt_o,
  output logic          tc_o,
  output logic          evt_o,
  output logic          irq_o
);
  localparam logic [CW-1:0] ALL_ONES = '1;
  localparam logic [CW-1:0] ONE      = {{(CW-1){1'b0}}, 1'b1};

  function automatic logic at_terminal(input logic [CW-1:0] v, input logic dn);
    return dn ? (v == '0) : (v == ALL_ONES);
  endfunction

  function automatic logic [CW-1:0] step(input logic [CW-1:0] v, input logic dn);
    return dn ? (v - ONE) : (v + ONE);
  endfunction

  ctrl_t         ctrl_q;
  logic          sts_q;
  logic          evt_q;
  logic [CW-1:0] load_q, cnt_q, capt_q;
  logic [31:0]   load_ext, load_merged;

  // named internal events
  logic tick, tc_hit, load_req, cap_edge, cap_fire, clr_req, set_ev;

  assign tick     = ctrl_q.run & ~freeze_i;
  assign tc_hit   = tick & ~ctrl_q.cap_mode & at_terminal(cnt_q, ctrl_q.down);
  assign load_req = (ctrl_we_i & be_i[0] & wdata_i[B_LDNOW]) | sync_i;
  assign cap_fire = ctrl_q.run & ctrl_q.cap_mode & cap_edge;
  assign clr_req  = ctrl_we_i & be_i[1] & wdata_i[B_STS];
  assign set_ev   = tc_hit | cap_fire;

  dtmr_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .din_i  (cap_i),
    .fall_i (ctrl_q.fall),
    .hit_o  (cap_edge)
  );

  always_comb begin
    load_ext           = '0;
    load_ext[CW-1:0]   = load_q;
  end
  assign load_merged = be_merge(load_ext, wdata_i, be_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      load_q <= '0;
    end else begin
      if (ctrl_we_i && be_i[0]) ctrl_q <= ctrl_t'(wdata_i[6:0]);
      if (tc_hit && !ctrl_q.auto_rl) ctrl_q.run <= 1'b0;
      if (load_we_i) load_q <= load_merged[CW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load_req) begin
      cnt_q <= load_q;
    end else if (tick) begin
      if (tc_hit) cnt_q <= load_q;
      else        cnt_q <= step(cnt_q, ctrl_q.down);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      capt_q <= '0;
      sts_q  <= 1'b0;
      evt_q  <= 1'b0;
    end else begin
      if (cap_fire) capt_q <= cnt_q;
      if (set_ev)       sts_q <= 1'b1;
      else if (clr_req) sts_q <= 1'b0;
      evt_q <= tc_hit;
    end
  end

  assign ctrl_o = {23'd0, sts_q, 1'b0, ctrl_q};
  assign load_o = load_q;
  assign cnt_o  = cnt_q;
  assign capt_o = capt_q;
  assign tc_o   = tc_hit;
  assign evt_o  = evt_q;
  assign irq_o  = sts_q & ctrl_q.ien;

  // R3
  reload_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tc_hit && ctrl_q.auto_rl |=> cnt_q == $past(load_q));
  // R4
  oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tc_hit && !ctrl_q.auto_rl |=> !ctrl_q.run);
  // R6
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_ev |=> sts_q);
  // R7
  capture_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_fire |=> capt_q == $past(cnt_q));
  // R8
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    freeze_i && !load_req |=> $stable(cnt_q));
endmodule

// File: rtl/dual_tmr_pwm.sv
module dual_tmr_pwm
  import dtmr_pkg::*;
#(
  parameter int CW = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        freeze,
  input  logic        reg_we,
  input  logic [2:0]  reg_addr,
  input  logic [3:0]  reg_be,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic [1:0]  cap_in,
  output logic [1:0]  evt_out,
  output logic [1:0]  irq_out,
  output logic        pwm_out
);
  localparam int NT = 2;

  logic [31:0]   ctrl_rd [NT];
  logic [CW-1:0] load_rd [NT];
  logic [CW-1:0] cnt_rd  [NT];
  logic [CW-1:0] capt_rd [NT];
  logic [NT-1:0] ctrl_we, load_we, chan_sync, tc;
  logic          pwm_on, pwm_q;
  reg_sel_e      sel;

  assign sel    = reg_sel_e'(reg_addr[1:0]);
  assign pwm_on = ctrl_rd[0][B_PWM];

  for (genvar t = 0; t < NT; t++) begin : g_tmr
    assign ctrl_we[t]   = reg_we && (int'(reg_addr[2]) == t) && (sel == SEL_CTRL);
    assign load_we[t]   = reg_we && (int'(reg_addr[2]) == t) && (sel == SEL_LOAD);
    assign chan_sync[t] = (t == 1) ? (pwm_on & tc[0]) : 1'b0;

    dtmr_chan #(.CW(CW)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .freeze_i  (freeze),
      .ctrl_we_i (ctrl_we[t]),
      .load_we_i (load_we[t]),
      .wdata_i   (reg_wdata),
      .be_i      (reg_be),
      .sync_i    (chan_sync[t]),
      .cap_i     (cap_in[t]),
      .ctrl_o    (ctrl_rd[t]),
      .load_o    (load_rd[t]),
      .cnt_o     (cnt_rd[t]),
      .capt_o    (capt_rd[t]),
      .tc_o      (tc[t]),
      .evt_o     (evt_out[t]),
      .irq_o     (irq_out[t])
    );
  end

  always_comb begin
    reg_rdata = '0;
    unique case (sel)
      SEL_CTRL:  reg_rdata           = ctrl_rd[reg_addr[2]];
      SEL_LOAD:  reg_rdata[CW-1:0]   = load_rd[reg_addr[2]];
      SEL_COUNT: reg_rdata[CW-1:0]   = cnt_rd[reg_addr[2]];
      SEL_CAPT:  reg_rdata[CW-1:0]   = capt_rd[reg_addr[2]];
      default:   reg_rdata           = '0;
    endcase
  end

  // period start (timer 0 reload) has priority over the end of the high phase
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pwm_q <= 1'b0;
    else if (!pwm_on) pwm_q <= 1'b0;
    else if (tc[0])   pwm_q <= 1'b1;
    else if (tc[1])   pwm_q <= 1'b0;
  end

  assign pwm_out = pwm_q;

  // R9
  pwm_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwm_q) |-> $past(tc[0]));
  // R8
  pwm_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    freeze && pwm_on && !reg_we |=> $stable(pwm_q));
endmodule

// File: tb/dual_tmr_pwm_bench.sv
`timescale 1ns/1ps
module dual_tmr_pwm_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        freeze = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [3:0]  reg_be = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [1:0]  cap_in = '0;
  logic [1:0]  evt_out, irq_out;
  logic        pwm_out;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  dual_tmr_pwm #(.CW(8)) u_dual_tmr_pwm (
    .clk(clk), .rst_n(rst_n), .freeze(freeze), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_be(reg_be), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .cap_in(cap_in), .evt_out(evt_out),
    .irq_out(irq_out), .pwm_out(pwm_out)
  );

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d, input logic [3:0] b);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d; reg_be = b;
    @(negedge clk);
    reg_we = 1'b0; reg_be = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic halt(input int t);
    wr(3'(t*4), 32'h100, 4'b0011);
    wr(3'(t*4), 32'h100, 4'b0011);
  endtask

  task automatic measure(input int ch, input int gap, input string tag);
    int last = -1;
    int seen = 0;
    for (int i = 0; i < 600 && seen < 4; i++) begin
      @(negedge clk);
      if (evt_out[ch]) begin
        if (last >= 0) chk(tag, i - last, gap);
        last = i;
        seen++;
      end
    end
    chk(tag, seen, 4);
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] v, c, c2, c3;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      chk("R1 reg", int'(v), 0);
    end
    chk("R1 outputs", int'({evt_out, irq_out, pwm_out}), 0);

    // R2 byte lanes
    wr(3'd1, 32'h0000_00A5, 4'b0001); rd(3'd1, v); chk("R2 lane0", int'(v), 'hA5);
    wr(3'd1, 32'hFFFF_FF5A, 4'b1110); rd(3'd1, v); chk("R2 masked", int'(v), 'hA5);
    wr(3'd0, 32'h0000_007F, 4'b0000); rd(3'd0, v); chk("R2 ctrl masked", int'(v), 0);

    // R11 read-only registers
    wr(3'd3, 32'hFF, 4'hF); rd(3'd3, v); chk("R11 capt", int'(v), 0);
    wr(3'd2, 32'h44, 4'hF); rd(3'd2, v); chk("R11 count", int'(v), 0);

    // R10 load-now
    wr(3'd0, 32'h80, 4'b0001);
    rd(3'd2, v); chk("R10 count", int'(v), 'hA5);
    rd(3'd0, v); chk("R10 bit7 reads 0", int'(v), 0);

    // R3 interval sweep, down on timer 0, up on timer 1
    for (int L = 0; L < 6; L++) begin
      wr(3'd1, 32'(L), 4'b0001);
      wr(3'd0, 32'h8D, 4'b0001);
      measure(0, L + 1, "R3 down");
      halt(0);
    end
    for (int L = 250; L < 256; L++) begin
      wr(3'd5, 32'(L), 4'b0001);
      wr(3'd4, 32'h89, 4'b0001);
      measure(1, 256 - L, "R3 up");
      halt(1);
    end

    // R4 one-shot
    wr(3'd5, 32'd3, 4'b0001);
    wr(3'd4, 32'h95, 4'b0001);
    n = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (evt_out[1]) n++;
    end
    chk("R4 single event", n, 1);
    rd(3'd4, v); chk("R4 run cleared", int'(v), 'h114);
    rd(3'd6, v); chk("R4 reloaded", int'(v), 3);
    chk("R5 irq", int'(irq_out[1]), 1);

    // R5 write-one-to-clear
    wr(3'd4, 32'h114, 4'b0001); rd(3'd4, v); chk("R5 lane1 off", int'(v), 'h114);
    wr(3'd4, 32'h014, 4'b0011); rd(3'd4, v); chk("R5 write 0", int'(v), 'h114);
    wr(3'd4, 32'h114, 4'b0011); rd(3'd4, v); chk("R5 cleared", int'(v), 'h014);
    chk("R5 irq low", int'(irq_out[1]), 0);

    // R6 set wins over clear
    wr(3'd1, 32'd0, 4'b0001);
    wr(3'd0, 32'h9D, 4'b0001);
    wr(3'd0, 32'h11D, 4'b0011); rd(3'd0, v); chk("R6 clear lost", int'(v), 'h11D);
    wr(3'd0, 32'h100, 4'b0011); rd(3'd0, v); chk("R6 stop write", int'(v), 'h100);
    wr(3'd0, 32'h100, 4'b0011); rd(3'd0, v); chk("R6 idle clear", int'(v), 0);

    // R8 freeze
    wr(3'd1, 32'd200, 4'b0001);
    wr(3'd0, 32'h8D, 4'b0001);
    wr(3'd5, 32'd0, 4'b0001);
    wr(3'd4, 32'h8D, 4'b0001);
    repeat (5) @(negedge clk);
    freeze = 1'b1;
    @(negedge clk);
    rd(3'd2, c);
    n = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (evt_out != 2'b00) n++;
    end
    chk("R8 no events", n, 0);
    rd(3'd2, c2); chk("R8 count held", int'(c2), int'(c));
    @(negedge clk); freeze = 1'b0;
    repeat (3) @(negedge clk);
    rd(3'd2, c3); chk("R8 resumes", int'(c3 < c), 1);
    halt(0); halt(1);

    // R7 capture, rising edge
    wr(3'd5, 32'h40, 4'b0001);
    wr(3'd4, 32'h93, 4'b0001);
    repeat (7) @(negedge clk);
    freeze = 1'b1;
    @(negedge clk);
    rd(3'd6, c);
    @(negedge clk); cap_in[1] = 1'b1;
    repeat (4) @(negedge clk);
    rd(3'd7, v); chk("R7 captured", int'(v), int'(c));
    rd(3'd4, v); chk("R7 status", int'(v), 'h113);
    chk("R7 irq", int'(irq_out[1]), 1);
    chk("R7 no event", int'(evt_out[1]), 0);
    // falling edge selected, interrupt disabled
    wr(3'd4, 32'h123, 4'b0011);
    freeze = 1'b0;
    repeat (5) @(negedge clk);
    freeze = 1'b1;
    @(negedge clk);
    rd(3'd6, c2); chk("R7 counted on", int'(c2 != c), 1);
    @(negedge clk); cap_in[1] = 1'b0;
    repeat (4) @(negedge clk);
    rd(3'd7, v); chk("R7 falling captured", int'(v), int'(c2));
    rd(3'd4, v); chk("R7 falling status", int'(v), 'h123);
    chk("R5 irq masked", int'(irq_out[1]), 0);
    // rising edge ignored while falling selected
    wr(3'd4, 32'h123, 4'b0011);
    freeze = 1'b0;
    repeat (5) @(negedge clk);
    freeze = 1'b1;
    @(negedge clk);
    @(negedge clk); cap_in[1] = 1'b1;
    repeat (4) @(negedge clk);
    rd(3'd7, v); chk("R7 other edge ignored", int'(v), int'(c2));
    rd(3'd4, v); chk("R7 other edge no status", int'(v), 'h23);
    freeze = 1'b0;
    halt(1);

    // R9 PWM sweep
    foreach (n_p[i]) begin end
    for (int pi = 0; pi < 2; pi++) begin
      int p;
      p = (pi == 0) ? 3 : 5;
      for (int hi = 0; hi < 5; hi++) begin
        int h, highs;
        h = (hi < 3) ? hi : ((hi == 3) ? p : p + 2);
        wr(3'd1, 32'(p), 4'b0001);
        wr(3'd5, 32'(h), 4'b0001);
        wr(3'd4, 32'h0D, 4'b0001);
        wr(3'd0, 32'hCD, 4'b0001);
        repeat (2 * (p + 1) + 2) @(negedge clk);
        highs = 0;
        for (int i = 0; i < 3 * (p + 1); i++) begin
          @(negedge clk);
          if (pwm_out) highs++;
        end
        chk("R9 high cycles", highs, 3 * ((h < p) ? h + 1 : p + 1));
        halt(0); halt(1);
        chk("R9 disabled low", int'(pwm_out), 0);
      end
    end

    // R8 PWM level held while frozen
    wr(3'd1, 32'd5, 4'b0001);
    wr(3'd5, 32'd2, 4'b0001);
    wr(3'd4, 32'h0D, 4'b0001);
    wr(3'd0, 32'hCD, 4'b0001);
    repeat (15) @(negedge clk);
    freeze = 1'b1;
    @(negedge clk);
    begin
      logic lvl;
      lvl = pwm_out;
      n = 0;
      for (int i = 0; i < 12; i++) begin
        @(negedge clk);
        if (pwm_out != lvl) n++;
      end
    end
    chk("R8 pwm held", n, 0);
    freeze = 1'b0;
    halt(0); halt(1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  int n_p [1];
endmodule